// File: doc/BRIEF.md
# Three-Channel DMA Priority Arbiter

This block decides which of three DMA channels owns a single shared transfer bus. Each channel raises a request line, and software can mask each request on its own. The arbiter grants the bus to one channel at a time through a one-hot grant vector. The owner keeps the bus until it reports that its current unit (single mode) or its block or burst segment has finished. The arbiter does not move any data.

A configuration input chooses between two orders. In the fixed order, channel 0 ranks highest and channel 2 lowest. In the rotating order, the channel that was just served drops to the lowest rank. A second option makes the chosen grant wait for the processor's instruction-boundary signal. The winner is selected when arbitration runs and is not changed while the grant waits.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `grant_o` is 3'b000 after that edge, and the rotating order restarts with channel 0 on top.
- R2: `grant_o` is always one-hot or zero. It stays 3'b000 while no channel has both `req_i[k]` and `req_en_i[k]` high.
- R3: A request whose `req_en_i[k]` bit is 0 is never granted, even when it outranks every other request.
- R4: With `rotate_i`=0, the enabled requests rank 0 first, then 1, then 2, every time arbitration runs.
- R5: With `rotate_i`=1, after channel k is released the order becomes k+1, k+2, k (modulo 3). Before the first release after reset, the order is 0, 1, 2.
- R6: Once a grant is issued, `grant_o` does not change until `seg_done_i` is sampled high. Requests from higher-ranked channels do not change it.
- R7: When `seg_done_i` is high at an edge while a grant is active, `grant_o` is 3'b000 after that edge. Arbitration runs again at the following edge.
- R8: With `wait_boundary_i`=0, an enabled request sampled at an edge while no grant is active and no grant is pending produces the grant right after that same edge.
- R9: With `wait_boundary_i`=1, the winner is latched when arbitration runs. It is granted after the first edge at which `instr_done_i` (or `wait_boundary_i`=0) is sampled. Request changes during the wait do not alter the latched winner.
- R10: A `seg_done_i` pulse while no grant is active has no effect on the grant or on the rotating order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 3 | Request line of each channel |
| req_en_i | input | 3 | Per-channel request enable; 0 masks the request |
| rotate_i | input | 1 | 1 selects rotating order, 0 selects fixed order |
| wait_boundary_i | input | 1 | 1 makes a new grant wait for `instr_done_i` |
| instr_done_i | input | 1 | Processor instruction-boundary strobe |
| seg_done_i | input | 1 | Owner's unit/block/segment finished |
| grant_o | output | 3 | One-hot grant, bit k for channel k |

## Verification
The bench raises a higher-ranked request while a lower channel owns the bus. A design that preempts the owner would switch the grant there. Rotation is walked through a full cycle of three releases, and a stray done pulse is sent with no owner. A pointer that moves on every done pulse, or that never moves, would then produce the wrong grant order. In wait mode the bench holds the grant off for several cycles and changes the requests during the wait. A design that grants early, or that re-arbitrates when the boundary arrives, would give the wrong channel or the wrong cycle. Masked top-priority requests and all-masked request sets show whether the enable vector is ignored.

// File: rtl/dma_arb_pkg.sv
// Package: shared types and helpers for the DMA priority arbiter.
// Assumes: channel indices fit in the width computed by callers.
package dma_arb_pkg;

    // Arbitration controller states.
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_WAIT = 2'd1,
        ARB_OWN  = 2'd2
    } arb_state_e;

endpackage

// File: rtl/dma_arb_pick.sv
// Module: combinational winner selection.
// Scans the effective requests starting at index top_i and wrapping
// around. The first set bit wins and is returned one-hot.
// Assumes: top_i < N_CH.
module dma_arb_pick #(
    parameter int N_CH = 3,
    localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [N_CH-1:0] req_eff_i,
    input  logic [IW-1:0]   top_i,
    output logic [N_CH-1:0] win_o,
    output logic            any_o
);

    // Circular first-set search beginning at top_i.
    always_comb begin
        logic found;
        int   idx;
        win_o = '0;
        found = 1'b0;
        for (int k = 0; k < N_CH; k++) begin
            idx = int'(top_i) + k;
            if (idx >= N_CH) idx = idx - N_CH;
            if (!found && req_eff_i[idx]) begin
                win_o[idx] = 1'b1;
                found      = 1'b1;
            end
        end
        any_o = found;
    end

endmodule

// File: rtl/dma_arb_rotor.sv
// Module: rotating-priority pointer.
// Holds the index of the highest-ranked channel for rotating mode. On a
// release it moves to the channel after the one that was served.
// Assumes: owner_idx_i is valid whenever advance_i is high.
module dma_arb_rotor #(
    parameter int N_CH = 3,
    localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance_i,
    input  logic [IW-1:0] owner_idx_i,
    output logic [IW-1:0] top_o
);

    localparam logic [IW-1:0] LAST = IW'(N_CH - 1);

    // Advance the top pointer past the channel just released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_o <= '0;
        end else if (advance_i) begin
            top_o <= (owner_idx_i == LAST) ? '0 : owner_idx_i + 1'b1;
        end
    end

endmodule

// File: rtl/dma_arb_ctrl.sv
// Module: grant controller.
// Issues, holds and releases the registered one-hot grant. It can park a
// latched winner until the processor instruction boundary arrives.
// Assumes: win_i is one-hot whenever any_i is high.
module dma_arb_ctrl
    import dma_arb_pkg::*;
#(
    parameter int N_CH = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] win_i,
    input  logic            any_i,
    input  logic            wait_boundary_i,
    input  logic            instr_done_i,
    input  logic            seg_done_i,
    output logic [N_CH-1:0] grant_o,
    output logic            release_o
);

    arb_state_e      state_q;
    logic [N_CH-1:0] pend_q;
    logic            go_now;

    // The grant may be issued now unless a boundary wait is in force.
    assign go_now    = !wait_boundary_i || instr_done_i;
    // The owner gives up the bus this cycle.
    assign release_o = (state_q == ARB_OWN) && seg_done_i;

    // State, pending winner and grant register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            pend_q  <= '0;
            grant_o <= '0;
        end else begin
            case (state_q)
                ARB_IDLE: begin
                    if (any_i) begin
                        if (go_now) begin
                            grant_o <= win_i;
                            state_q <= ARB_OWN;
                        end else begin
                            pend_q  <= win_i;
                            state_q <= ARB_WAIT;
                        end
                    end
                end
                ARB_WAIT: begin
                    if (go_now) begin
                        grant_o <= pend_q;
                        state_q <= ARB_OWN;
                    end
                end
                ARB_OWN: begin
                    if (seg_done_i) begin
                        grant_o <= '0;
                        state_q <= ARB_IDLE;
                    end
                end
                default: state_q <= ARB_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_prio_arbiter.sv
// Module: top of the DMA channel priority arbiter.
// Masks the requests, picks the top rank from the fixed or the rotating
// order, and drives the grant controller.
// Assumes: seg_done_i comes from the current owner only.
module dma_prio_arbiter #(
    parameter int N_CH = 3,
    localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] req_i,
    input  logic [N_CH-1:0] req_en_i,
    input  logic            rotate_i,
    input  logic            wait_boundary_i,
    input  logic            instr_done_i,
    input  logic            seg_done_i,
    output logic [N_CH-1:0] grant_o
);

    logic [N_CH-1:0] req_eff;
    logic [N_CH-1:0] win;
    logic            any;
    logic [IW-1:0]   rr_top;
    logic [IW-1:0]   top_sel;
    logic [IW-1:0]   owner_idx;
    logic            release_w;

    // Apply the per-channel enables.
    assign req_eff = req_i & req_en_i;
    // Fixed order always starts at channel 0.
    assign top_sel = rotate_i ? rr_top : '0;

    // Encode the one-hot owner into an index.
    always_comb begin
        owner_idx = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (grant_o[i]) owner_idx = IW'(i);
        end
    end

    dma_arb_pick #(.N_CH(N_CH)) u_pick (
        .req_eff_i (req_eff),
        .top_i     (top_sel),
        .win_o     (win),
        .any_o     (any)
    );

    dma_arb_rotor #(.N_CH(N_CH)) u_rotor (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance_i   (release_w),
        .owner_idx_i (owner_idx),
        .top_o       (rr_top)
    );

    dma_arb_ctrl #(.N_CH(N_CH)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .win_i           (win),
        .any_i           (any),
        .wait_boundary_i (wait_boundary_i),
        .instr_done_i    (instr_done_i),
        .seg_done_i      (seg_done_i),
        .grant_o         (grant_o),
        .release_o       (release_w)
    );

endmodule

// File: rtl/dma_arb_chk.sv
// Module: property checker for dma_prio_arbiter, attached through bind.
// Assumes: only the top-level ports are observed.
module dma_arb_chk #(
    parameter int N_CH = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wait_boundary_i,
    input logic            instr_done_i,
    input logic            seg_done_i,
    input logic [N_CH-1:0] grant_o
);

    // R1: synchronous reset clears the grant.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> grant_o == '0);

    // R2: at most one channel granted.
    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R6: the owner keeps the grant until done.
    assert_hold_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o && !seg_done_i) |=> grant_o == $past(grant_o));

    // R7: done releases the grant.
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o && seg_done_i) |=> grant_o == '0);

    // R9: under boundary wait, a new grant follows an instruction boundary.
    assert_boundary_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o && $past(grant_o) == '0 && $past(wait_boundary_i))
            |-> $past(instr_done_i));

endmodule

bind dma_prio_arbiter dma_arb_chk #(.N_CH(N_CH)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wait_boundary_i (wait_boundary_i),
    .instr_done_i    (instr_done_i),
    .seg_done_i      (seg_done_i),
    .grant_o         (grant_o)
);

// File: tb/tb_dma_prio_arbiter.sv
// Directed bench for dma_prio_arbiter: one task per scenario.
module tb_dma_prio_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req_i = '0;
    logic [2:0] req_en_i = '0;
    logic       rotate_i = 1'b0;
    logic       wait_boundary_i = 1'b0;
    logic       instr_done_i = 1'b0;
    logic       seg_done_i = 1'b0;
    logic [2:0] grant_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    dma_prio_arbiter dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_i           (req_i),
        .req_en_i        (req_en_i),
        .rotate_i        (rotate_i),
        .wait_boundary_i (wait_boundary_i),
        .instr_done_i    (instr_done_i),
        .seg_done_i      (seg_done_i),
        .grant_o         (grant_o)
    );

    // Advance to just after the next rising edge.
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [2:0] exp);
        n_cmp++;
        if (grant_o !== exp) begin
            n_bad++;
            $display("FAIL %s: grant got %b expected %b", tag, grant_o, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_i = '0; req_en_i = 3'b111; rotate_i = 1'b0;
        wait_boundary_i = 1'b0; instr_done_i = 1'b0; seg_done_i = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    // Pulse done for one edge; grant must drop (R7).
    task automatic finish_seg(input string tag);
        seg_done_i = 1'b1;
        step();
        seg_done_i = 1'b0;
        chk(tag, 3'b000);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset", 3'b000);
        step();
        chk("R2 no request", 3'b000);
    endtask

    task automatic t_fixed();
        do_reset();
        req_i = 3'b111;
        chk("R8 not before edge", 3'b000);
        step();
        chk("R8/R4 all req -> ch0", 3'b001);
        finish_seg("R7 release");
        step();
        chk("R4 fixed again ch0", 3'b001);
        finish_seg("R7 release 2");
        req_i = 3'b110;
        step();
        chk("R4 ch1 over ch2", 3'b010);
        finish_seg("R7 release 3");
        req_i = 3'b100;
        step();
        chk("R4 ch2 alone", 3'b100);
        req_i = 3'b000;
        finish_seg("R7 release 4");
        step();
        chk("R2 no req after release", 3'b000);
    endtask

    task automatic t_mask();
        do_reset();
        req_i = 3'b111; req_en_i = 3'b110;
        step();
        chk("R3 ch0 masked", 3'b010);
        req_en_i = 3'b000;
        finish_seg("R7 release mask");
        step();
        chk("R3/R2 all masked", 3'b000);
        step();
        chk("R3 still none", 3'b000);
    endtask

    task automatic t_hold();
        do_reset();
        req_i = 3'b100;
        step();
        chk("R6 ch2 granted", 3'b100);
        req_i = 3'b111;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R6 held against ch0", 3'b100);
        end
        finish_seg("R7 release hold");
        step();
        chk("R4 ch0 after hold", 3'b001);
    endtask

    task automatic t_rotate();
        do_reset();
        rotate_i = 1'b1; req_i = 3'b111;
        step();
        chk("R5 first ch0", 3'b001);
        finish_seg("R7 rot rel0");
        step();
        chk("R5 then ch1", 3'b010);
        finish_seg("R7 rot rel1");
        step();
        chk("R5 then ch2", 3'b100);
        finish_seg("R7 rot rel2");
        step();
        chk("R5 wrap ch0", 3'b001);
        finish_seg("R7 rot rel3");
        req_i = 3'b101;
        step();
        chk("R5 ch1 idle, ch2 next", 3'b100);
    endtask

    task automatic t_idle_done();
        do_reset();
        rotate_i = 1'b1;
        seg_done_i = 1'b1;
        step();
        seg_done_i = 1'b0;
        chk("R10 stray done no grant", 3'b000);
        req_i = 3'b111;
        step();
        chk("R10 order unchanged", 3'b001);
    endtask

    task automatic t_wait();
        do_reset();
        wait_boundary_i = 1'b1; req_i = 3'b010;
        step();
        chk("R9 waiting", 3'b000);
        req_i = 3'b011;
        step();
        chk("R9 still waiting", 3'b000);
        step();
        chk("R9 still waiting 2", 3'b000);
        instr_done_i = 1'b1;
        step();
        instr_done_i = 1'b0;
        chk("R9 latched ch1 granted", 3'b010);
        finish_seg("R7 wait release");
        instr_done_i = 1'b1;
        step();
        instr_done_i = 1'b0;
        chk("R9 boundary same cycle", 3'b001);
    endtask

    initial begin
        t_reset();
        t_fixed();
        t_mask();
        t_hold();
        t_rotate();
        t_idle_done();
        t_wait();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule